// File: doc/BRIEF.md
# Programmable-Order CIC Decimation Filter

This block takes a stream of signed 14-bit converter samples. It lowers their rate by a programmable ratio D with a cascaded integrator-comb structure of order N. Each accepted sample is sign-extended to 26 bits and shifted left by a programmable pre-shift. It then passes through N integrators that run at the input rate. Every D-th integrator result goes to N comb stages, which run at the decimated rate. All of these registers use 26-bit two's-complement arithmetic and wrap freely. The result is still exact as long as the true filtered value fits in 26 bits.

After the combs, a programmable signed offset is added once. The sum is shifted right arithmetically by a programmable amount and saturated to a signed 24-bit value. That value is then placed left-aligned in a 32-bit word, so the low byte is always zero. The DC gain before scaling is D^N times 2^pre-shift. The software picks the two shifts so that the full-scale result fits the output.

A two-state controller has the states ST_IDLE and ST_RUN. Transition T_START (ST_IDLE to ST_RUN) fires on the first clock with `en` high, and the configuration is captured on that same clock. Transition T_STOP (ST_RUN to ST_IDLE) fires on any clock with `en` low. Whenever the block is not running, it clears every delay register, the decimation counter and the output pipeline.

Top module: `cic_decim`

## Requirements
- R1: Integrator and comb registers are 26-bit two's complement and wrap on overflow. The output equals the modular CIC result: for order 2, ratio 32, pre-shift 0, post-shift 10 and a constant input of 8000, the steady output is 8000 (word 0x001F4000) even though the integrators overflow.
- R2: An accepted sample is sign-extended from 14 to 26 bits and shifted left by the captured pre-shift before the first integrator. With order 1, ratio 2, pre-shift 3 and post-shift 0, two samples of -5 give -80 (word 0xFFFFB000).
- R3: A decimation counter advances on each accepted sample and restarts after D samples. Exactly one output is produced per D accepted samples, and the counter is always below D.
- R4: A captured order of 0 is treated as 1 and an order above 5 as 5. A captured ratio below 2 is treated as 2 and a ratio above 512 as 512.
- R5: The 26-bit signed offset is added once, after the combs and before the post-shift. Order 1, ratio 2, offset 7 and a constant input of 100 give 207.
- R6: The post stage shifts arithmetically right by the captured post-shift and saturates to the signed 24-bit range. The largest word is 0x7FFFFF00 and the smallest is 0x80000000.
- R7: Bits 7:0 of `out_data` are zero whenever `out_valid` is high, and bits 31:8 carry the 24-bit result.
- R8: `out_valid` is high for exactly one cycle per decimated sample. It is visible in the cycle after the second rising edge that follows the edge that accepted the D-th sample.
- R9: Order, ratio, both shifts and the offset are captured only on T_START. Changes to the configuration inputs while in ST_RUN have no effect.
- R10: In ST_IDLE, and on any clock with `en` low, samples are ignored. Integrators, combs, the counter and the output pipeline are cleared, so no `out_valid` follows.
- R11: A synchronous reset enters ST_IDLE and drives `out_valid` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; its rising use captures the configuration |
| cfg_order | input | 3 | Filter order N (1 to 5) |
| cfg_ratio | input | 10 | Decimation ratio D (2 to 512) |
| cfg_pre_shift | input | 4 | Left shift applied to each sample |
| cfg_offset | input | 26 | Signed offset added after the combs |
| cfg_post_shift | input | 5 | Arithmetic right shift of the scale stage |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 14 | Signed input sample |
| out_valid | output | 1 | One-cycle output qualifier |
| out_data | output | 32 | Left-aligned signed result, low byte zero |

## Verification
The D-th sample is accepted on edge k. Its integrator value is registered on edge k, the comb difference on edge k+1, and the scaled word on edge k+2. The result is therefore due in the cycle after edge k+2. The bench model shifts its expected value and valid flag through a two-slot queue at each rising edge. It also clears that queue on every clock where the block would clear. The outputs are compared at each falling edge, so every cycle is checked in the cycle where the result is due. The latency check counts edges from the last drive. The counting checks wait a fixed settle time after each burst before they read the output count.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int CIC_DW   = 26;   // internal datapath width
    localparam int CIC_IW   = 14;   // input sample width
    localparam int CIC_NMAX = 5;    // highest order
    localparam int CIC_OW   = 3;    // order field width
    localparam int CIC_RW   = 10;   // ratio field width
    localparam int CIC_RMAX = 512;  // highest ratio
    localparam int CIC_SW   = 4;    // pre-shift field width
    localparam int CIC_CW   = 5;    // post-shift field width
    localparam int CIC_RESW = 24;   // saturated result width
    localparam int CIC_WW   = 32;   // output word width

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1
    } cic_state_e;

endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
    parameter int DW   = 26,
    parameter int NMAX = 5,
    parameter int OW   = 3
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 step,
    input  logic [OW-1:0]        order,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] sum
);

    logic signed [DW-1:0] chain [NMAX+1];

    assign chain[0] = din;

    for (genvar k = 0; k < NMAX; k++) begin : g_stage
        localparam logic [OW-1:0] IDX = OW'(k);
        logic                 active;
        logic signed [DW-1:0] acc_q;

        assign active       = (IDX < order);
        assign chain[k+1]   = active ? (acc_q + chain[k]) : chain[k];

        always_ff @(posedge clk) begin
            if (clr) begin
                acc_q <= '0;
            end else if (step && active) begin
                acc_q <= chain[k+1];
            end
        end
    end

    assign sum = chain[NMAX];

endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
    parameter int DW   = 26,
    parameter int NMAX = 5,
    parameter int OW   = 3
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 step,
    input  logic [OW-1:0]        order,
    input  logic signed [DW-1:0] din,
    output logic                 dout_valid,
    output logic signed [DW-1:0] dout
);

    logic signed [DW-1:0] chain [NMAX+1];

    assign chain[0] = din;

    for (genvar k = 0; k < NMAX; k++) begin : g_stage
        localparam logic [OW-1:0] IDX = OW'(k);
        logic                 active;
        logic signed [DW-1:0] dly_q;

        assign active     = (IDX < order);
        assign chain[k+1] = active ? (chain[k] - dly_q) : chain[k];

        always_ff @(posedge clk) begin
            if (clr) begin
                dly_q <= '0;
            end else if (step && active) begin
                dly_q <= chain[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= step;
        end
        if (step) begin
            dout <= chain[NMAX];
        end
    end

endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
    parameter int DW   = 26,
    parameter int CW   = 5,
    parameter int RESW = 24,
    parameter int WW   = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 din_valid,
    input  logic signed [DW-1:0] din,
    input  logic signed [DW-1:0] offset,
    input  logic [CW-1:0]        shift,
    output logic                 out_valid,
    output logic [WW-1:0]        out_data
);

    localparam int SUM_W = DW + 1;
    localparam int PAD_W = WW - RESW;
    localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'((2 ** (RESW - 1)) - 1);
    localparam logic signed [SUM_W-1:0] NEG_LIM = ~POS_LIM;

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] shifted;
    logic signed [RESW-1:0]  res;

    always_comb begin
        sum     = $signed({din[DW-1], din}) + $signed({offset[DW-1], offset});
        shifted = sum >>> shift;
        if (shifted > POS_LIM) begin
            res = POS_LIM[RESW-1:0];
        end else if (shifted < NEG_LIM) begin
            res = NEG_LIM[RESW-1:0];
        end else begin
            res = shifted[RESW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= din_valid && !clr;
            if (din_valid && !clr) begin
                out_data <= {res, {PAD_W{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/cic_decim.sv
module cic_decim
    import cic_pkg::*;
#(
    parameter int DW   = CIC_DW,
    parameter int IW   = CIC_IW,
    parameter int NMAX = CIC_NMAX,
    parameter int OW   = CIC_OW,
    parameter int RW   = CIC_RW,
    parameter int RMAX = CIC_RMAX,
    parameter int SW   = CIC_SW,
    parameter int CW   = CIC_CW,
    parameter int RESW = CIC_RESW,
    parameter int WW   = CIC_WW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [OW-1:0] cfg_order,
    input  logic [RW-1:0] cfg_ratio,
    input  logic [SW-1:0] cfg_pre_shift,
    input  logic [DW-1:0] cfg_offset,
    input  logic [CW-1:0] cfg_post_shift,
    input  logic          in_valid,
    input  logic [IW-1:0] in_sample,
    output logic          out_valid,
    output logic [WW-1:0] out_data
);

    localparam logic [OW-1:0] ORDER_MIN = OW'(1);
    localparam logic [OW-1:0] ORDER_MAX = OW'(NMAX);
    localparam logic [RW-1:0] RATIO_MIN = RW'(2);
    localparam logic [RW-1:0] RATIO_MAX = RW'(RMAX);

    cic_state_e state_q, state_d;

    logic                 running, clr, accept, fire;
    logic [OW-1:0]        ord_q;
    logic [RW-1:0]        ratio_q;
    logic [SW-1:0]        pre_q;
    logic signed [DW-1:0] off_q;
    logic [CW-1:0]        post_q;
    logic [RW-1:0]        dec_cnt;
    logic signed [DW-1:0] pre_val, int_sum, dec_d, cmb_d;
    logic                 dec_v, cmb_v;

    function automatic logic [OW-1:0] legal_order(input logic [OW-1:0] o);
        if (o < ORDER_MIN)      return ORDER_MIN;
        else if (o > ORDER_MAX) return ORDER_MAX;
        else                    return o;
    endfunction

    function automatic logic [RW-1:0] legal_ratio(input logic [RW-1:0] r);
        if (r < RATIO_MIN)      return RATIO_MIN;
        else if (r > RATIO_MAX) return RATIO_MAX;
        else                    return r;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_START (IDLE->RUN on en), T_STOP (RUN->IDLE on !en)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en)  state_d = ST_RUN;
            ST_RUN:  if (!en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state-decoded controls
    always_comb begin
        running = (state_q == ST_RUN) && en;
        clr     = rst || !running;
        accept  = running && in_valid;
        fire    = accept && (dec_cnt == (ratio_q - 1'b1));
    end

    // configuration capture on T_START
    always_ff @(posedge clk) begin
        if (rst) begin
            ord_q   <= ORDER_MIN;
            ratio_q <= RATIO_MIN;
            pre_q   <= '0;
            off_q   <= '0;
            post_q  <= '0;
        end else if ((state_q == ST_IDLE) && en) begin
            ord_q   <= legal_order(cfg_order);
            ratio_q <= legal_ratio(cfg_ratio);
            pre_q   <= cfg_pre_shift;
            off_q   <= cfg_offset;
            post_q  <= cfg_post_shift;
        end
    end

    // decimation counter and hand-off register
    always_ff @(posedge clk) begin
        if (clr) begin
            dec_cnt <= '0;
            dec_v   <= 1'b0;
        end else begin
            dec_v <= fire;
            if (accept) begin
                dec_cnt <= fire ? '0 : dec_cnt + 1'b1;
            end
        end
        if (fire) begin
            dec_d <= int_sum;
        end
    end

    always_comb begin
        pre_val = DW'($signed(in_sample));
        pre_val = pre_val <<< pre_q;
    end

    cic_integ #(.DW(DW), .NMAX(NMAX), .OW(OW)) u_integ (
        .clk   (clk),
        .clr   (clr),
        .step  (accept),
        .order (ord_q),
        .din   (pre_val),
        .sum   (int_sum)
    );

    cic_comb #(.DW(DW), .NMAX(NMAX), .OW(OW)) u_comb (
        .clk        (clk),
        .clr        (clr),
        .step       (dec_v),
        .order      (ord_q),
        .din        (dec_d),
        .dout_valid (cmb_v),
        .dout       (cmb_d)
    );

    cic_scale #(.DW(DW), .CW(CW), .RESW(RESW), .WW(WW)) u_scale (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .din_valid (cmb_v),
        .din       (cmb_d),
        .offset    (off_q),
        .shift     (post_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk
    import cic_pkg::*;
#(
    parameter int NMAX  = CIC_NMAX,
    parameter int OW    = CIC_OW,
    parameter int RW    = CIC_RW,
    parameter int RMAX  = CIC_RMAX,
    parameter int WW    = CIC_WW,
    parameter int SNAPW = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic [WW-1:0]    out_data,
    input cic_state_e       state,
    input logic [RW-1:0]    dec_cnt,
    input logic [RW-1:0]    ratio,
    input logic [OW-1:0]    order,
    input logic [SNAPW-1:0] cfg_snap
);

    // R3: counter never reaches the captured ratio
    p_cnt_below_ratio_r3: assert property (@(posedge clk) disable iff (rst)
        dec_cnt < ratio);

    // R4: captured order and ratio stay in the legal window
    p_cfg_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (ratio >= RW'(2)) && (ratio <= RW'(RMAX)) && (order >= OW'(1)) && (order <= OW'(NMAX)));

    // R7: low byte of a valid word is zero
    p_low_byte_zero_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[7:0] == 8'h00));

    // R8: valid is a single-cycle pulse
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R9: captured configuration holds while running
    p_cfg_held_r9: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN) && ($past(state) == ST_RUN)) |-> $stable(cfg_snap));

    // R10: idle clears the output pipeline
    p_idle_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> !out_valid);

endmodule

bind cic_decim cic_decim_chk #(
    .NMAX  (NMAX),
    .OW    (OW),
    .RW    (RW),
    .RMAX  (RMAX),
    .WW    (WW),
    .SNAPW (OW + RW + SW + DW + CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_data  (out_data),
    .state     (state_q),
    .dec_cnt   (dec_cnt),
    .ratio     (ratio_q),
    .order     (ord_q),
    .cfg_snap  ({ord_q, ratio_q, pre_q, off_q, post_q})
);

// File: tb/cic_decim_tb_top.sv
module cic_decim_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [2:0]  cfg_order = '0;
    logic [9:0]  cfg_ratio = '0;
    logic [3:0]  cfg_pre_shift = '0;
    logic [25:0] cfg_offset = '0;
    logic [4:0]  cfg_post_shift = '0;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic        out_valid;
    logic [31:0] out_data;

    always #10 clk = ~clk;   // 50 MHz

    cic_decim dut_i (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .cfg_order      (cfg_order),
        .cfg_ratio      (cfg_ratio),
        .cfg_pre_shift  (cfg_pre_shift),
        .cfg_offset     (cfg_offset),
        .cfg_post_shift (cfg_post_shift),
        .in_valid       (in_valid),
        .in_sample      (in_sample),
        .out_valid      (out_valid),
        .out_data       (out_data)
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int n_out = 0;
    int out_cyc = 0;
    int last_drive = 0;
    int pulse_err = 0;
    bit prev_v = 1'b0;
    bit done = 1'b0;
    logic [31:0] last_out = '0;

    // ---------------- behavioural reference ----------------
    longint acc [5];
    longint cd [5];
    int     m_cnt, m_ord, m_ratio, m_pre, m_post;
    longint m_off;
    bit     m_run = 1'b0;
    bit     m_clr;
    bit     nv, p1v = 1'b0, p2v = 1'b0, exv = 1'b0;
    logic [31:0] nd, p1d = '0, p2d = '0, exd = '0;
    longint x, y;

    function automatic longint wrap26(longint v);
        longint m;
        m = v & 64'h3FF_FFFF;
        if (m[25]) m = m - 64'h400_0000;
        return m;
    endfunction

    function automatic logic [31:0] to_word(longint c);
        longint s;
        s = (c + m_off) >>> m_post;
        if (s > 64'sd8388607)  s = 64'sd8388607;
        if (s < -64'sd8388608) s = -64'sd8388608;
        return {s[23:0], 8'h00};
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 5; k++) begin
            acc[k] = 0;
            cd[k]  = 0;
        end
        m_cnt = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        nv = 1'b0;
        nd = '0;
        m_clr = 1'b1;
        if (rst) begin
            m_run = 1'b0;
            model_clear();
        end else if (!m_run) begin
            if (en) begin
                m_ord   = (cfg_order == 0) ? 1 : ((cfg_order > 5) ? 5 : int'(cfg_order));
                m_ratio = (cfg_ratio < 2) ? 2 : ((cfg_ratio > 512) ? 512 : int'(cfg_ratio));
                m_pre   = int'(cfg_pre_shift);
                m_post  = int'(cfg_post_shift);
                m_off   = wrap26(longint'(cfg_offset));
                m_run   = 1'b1;
            end
            model_clear();
        end else if (!en) begin
            m_run = 1'b0;
            model_clear();
        end else begin
            m_clr = 1'b0;
            if (in_valid) begin
                x = wrap26(longint'($signed(in_sample)) <<< m_pre);
                for (int k = 0; k < m_ord; k++) begin
                    acc[k] = wrap26(acc[k] + x);
                    x = acc[k];
                end
                m_cnt++;
                if (m_cnt == m_ratio) begin
                    m_cnt = 0;
                    for (int k = 0; k < m_ord; k++) begin
                        y = wrap26(x - cd[k]);
                        cd[k] = x;
                        x = y;
                    end
                    nv = 1'b1;
                    nd = to_word(x);
                end
            end
        end
        if (m_clr) begin
            exv = 1'b0; p2v = 1'b0; p1v = 1'b0;
        end else begin
            exv = p2v; exd = p2d;
            p2v = p1v; p2d = p1d;
            p1v = nv;  p1d = nd;
        end
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL R8 watchdog: cycle %0d, expected completion below %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        vectors++;
        if (out_valid !== exv) begin
            fails++;
            $display("FAIL R8 cycle %0d out_valid actual %b expected %b", cyc, out_valid, exv);
        end
        if (exv && (out_data !== exd)) begin
            fails++;
            $display("FAIL R1 cycle %0d out_data actual %h expected %h", cyc, out_data, exd);
        end
        if (out_valid === 1'b1) begin
            last_out = out_data;
            n_out++;
            out_cyc = cyc;
            if (prev_v) pulse_err++;
        end
        prev_v = (out_valid === 1'b1);
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
        vectors++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, got, expv);
        end
    endtask

    task automatic start(input int o, input int r, input int ps, input int off, input int po);
        @(negedge clk);
        en = 1'b0;
        cfg_order = 3'(o);
        cfg_ratio = 10'(r);
        cfg_pre_shift = 4'(ps);
        cfg_offset = 26'(off);
        cfg_post_shift = 5'(po);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic feed(input int v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sample = 14'(v);
            last_drive = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic feed_rand(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = ($urandom_range(0, 3) != 0);
            in_sample = 14'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int n0;
        repeat (4) @(negedge clk);
        chk("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R11 reset out_data", out_data, 32'd0);
        rst = 1'b0;

        // R2: sign extension and pre-shift
        start(1, 2, 3, 0, 0);
        feed(-5, 2);
        settle();
        chk("R2 pre-shifted negative sample", last_out, 32'hFFFF_B000);

        // R8: latency and R3 single output
        start(1, 4, 0, 0, 0);
        n0 = n_out;
        feed(1000, 4);
        settle();
        chk("R8 latency edges", 32'(out_cyc - last_drive), 32'd3);
        chk("R3 one output per ratio", 32'(n_out - n0), 32'd1);
        chk("R8 latency value", last_out, 32'h000F_A000);

        // R3: output count under gaps
        start(2, 5, 0, 0, 0);
        n0 = n_out;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sample = 14'($urandom);
            @(negedge clk);
            in_valid = 1'b0;
        end
        settle();
        chk("R3 ten outputs for fifty samples", 32'(n_out - n0), 32'd10);

        // R5: offset applied once after combs
        start(1, 2, 0, 7, 0);
        feed(100, 6);
        settle();
        chk("R5 offset after combs", last_out, 32'h0000_CF00);

        // R6: saturation both ways
        start(2, 64, 0, 0, 0);
        feed(8191, 256);
        settle();
        chk("R6 positive saturation", last_out, 32'h7FFF_FF00);
        start(2, 64, 0, 0, 0);
        feed(-8192, 256);
        settle();
        chk("R6 negative saturation", last_out, 32'h8000_0000);

        // R1: wrapping integrators, exact output
        start(2, 32, 0, 0, 10);
        feed(8000, 480);
        settle();
        chk("R1 wrap-tolerant DC value", last_out, 32'h001F_4000);

        // R4: clamps
        start(0, 1, 0, 0, 0);
        n0 = n_out;
        feed(10, 8);
        settle();
        chk("R4 order0 ratio1 value", last_out, 32'h0000_1400);
        chk("R4 ratio1 treated as 2", 32'(n_out - n0), 32'd4);
        start(7, 1000, 0, 0, 25);
        n0 = n_out;
        feed(3, 1024);
        settle();
        chk("R4 ratio1000 treated as 512", 32'(n_out - n0), 32'd2);

        // R9: configuration held while running
        start(1, 4, 0, 0, 2);
        feed(300, 4);
        settle();
        chk("R9 baseline", last_out, 32'h0001_2C00);
        @(negedge clk);
        cfg_order = 3'd5; cfg_ratio = 10'd2; cfg_post_shift = 5'd0; cfg_offset = 26'd999;
        n0 = n_out;
        feed(300, 4);
        settle();
        chk("R9 count unchanged by live cfg", 32'(n_out - n0), 32'd1);
        chk("R9 value unchanged by live cfg", last_out, 32'h0001_2C00);

        // R10: disabled input ignored, state cleared
        start(1, 4, 0, 0, 2);
        feed(50, 2);
        @(negedge clk);
        en = 1'b0;
        n0 = n_out;
        feed(50, 20);
        settle();
        chk("R10 no output while disabled", 32'(n_out - n0), 32'd0);
        start(1, 4, 0, 0, 2);
        n0 = n_out;
        feed(77, 3);
        settle();
        chk("R10 counter cleared", 32'(n_out - n0), 32'd0);
        feed(77, 1);
        settle();
        chk("R10 first output after restart", 32'(n_out - n0), 32'd1);
        chk("R10 delay lines cleared", last_out, 32'h0000_4D00);

        // R1/R2/R7: random configurations against the model
        for (int r = 0; r < 6; r++) begin
            start($urandom_range(0, 7), $urandom_range(1, 40), $urandom_range(0, 15),
                  int'($urandom), $urandom_range(0, 31));
            feed_rand(220);
            settle();
            chk("R7 low byte zero", {24'd0, last_out[7:0]}, 32'd0);
        end

        chk("R8 single-cycle pulses", 32'(pulse_err), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule